// File: doc/BRIEF.md
# Byte and Word Load/Store Lane Unit

This block sits between a 32-bit core and a data memory organised as whole words. For each memory request it gets the operation code, the byte address the core has already computed, the register value to be stored and the word the memory returns for that address. It produces three things:

- the word address for the memory;
- a per-byte write enable with the matching write data;
- the value a load hands back to the register file.

Byte loads pick one lane of the returned word and sign-extend it to the full register. Word loads pass the whole word through. Byte stores enable one lane. Word stores enable all of them.

A parameter sets how byte addresses map onto lanes. With big-endian order, address offset 0 is the most significant byte of the word. With little-endian order, it is the least significant byte. All outputs are registered. The results of a request appear one clock after the edge that accepts it, and the memory write takes place on the clock edge after that.

Top module: `lsu_lane_unit`

## Requirements
- R1: A request is accepted when `req_valid` is high and `req_opcode` is one of 0x20 (byte load), 0x23 (word load), 0x28 (byte store) or 0x2B (word store). In the cycle after an idle cycle or an unknown opcode, `wr_mask`, `wr_data`, `load_valid` and `misaligned` are all zero, and `load_result` keeps its value.
- R2: A synchronous active-high reset clears `wr_mask`, `wr_data`, `wr_word_addr`, `load_valid`, `misaligned` and `load_result` to zero. Every other output value appears one clock after the edge that accepts the request.
- R3: Lane k is `mem_rdata`/`wr_data` bits [8k+7:8k]. The byte at address offset `req_addr[1:0]` uses lane 3 minus the offset when `BIG_ENDIAN` is 1, and lane equal to the offset when `BIG_ENDIAN` is 0.
- R4: A byte load returns the selected lane in bits [7:0], with bit 7 copied into bits [31:8].
- R5: A word load returns `mem_rdata` unchanged, and `load_valid` is high for one cycle.
- R6: A byte store sets exactly one bit of `wr_mask`: the bit for the selected lane. It places `req_store_data[7:0]` on all four lanes of `wr_data`.
- R7: A word store with `req_addr[1:0]` equal to 0 sets all four `wr_mask` bits and drives `req_store_data` unchanged on `wr_data`.
- R8: A word access with `req_addr[1:0]` not zero raises `misaligned` for one cycle. For such a store, `wr_mask` and `wr_data` are zero and no byte is written. Such a load still returns the word at the address with its low two bits cleared.
- R9: A load never sets any `wr_mask` bit. `wr_data` is zero whenever `wr_mask` is zero.
- R10: For every accepted request, `wr_word_addr` equals `req_addr[31:2]`.
- R11: After a word store of 0x00000005 to address 8, a byte load from address 11 returns 5 and one from address 8 returns 0 in big-endian order. In little-endian order the two results swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_opcode | input | 6 | Operation code |
| req_addr | input | 32 | Byte address (offset plus base register) |
| req_store_data | input | 32 | Register value to store |
| mem_rdata | input | 32 | Memory word at `req_addr[31:2]`, same cycle |
| wr_word_addr | output | 30 | Registered word address |
| wr_mask | output | 4 | Registered per-lane write enable |
| wr_data | output | 32 | Registered lane-aligned write data |
| load_valid | output | 1 | Load result updated this cycle |
| load_result | output | 32 | Value returned to the register file |
| misaligned | output | 1 | Word access with nonzero low address bits |

## Verification
On every cycle, the assertions check the shape of the write mask (none, one lane or all lanes), the replication of the byte on a byte store, and that loads and misaligned accesses write nothing. They also check the sign fill of byte loads, the pass-through of aligned word stores and the word address. Lane order under each endianness, and the values that come back after a store, can only be shown by the bench. Its scenarios drive a big-endian and a little-endian instance side by side. Each instance is attached to its own behavioural memory, and a byte-addressed reference model tracks both memories.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int OPC_W = 6;
  localparam logic [OPC_W-1:0] OPC_LD_BYTE = 6'h20;
  localparam logic [OPC_W-1:0] OPC_LD_WORD = 6'h23;
  localparam logic [OPC_W-1:0] OPC_ST_BYTE = 6'h28;
  localparam logic [OPC_W-1:0] OPC_ST_WORD = 6'h2B;

  typedef struct packed {
    logic active;
    logic is_store;
    logic is_word;
  } access_t;
endpackage

// File: rtl/lsu_access_decode.sv
module lsu_access_decode
  import lsu_pkg::*;
#(
  parameter int LANES      = 4,
  parameter bit BIG_ENDIAN = 1'b1,
  localparam int LANE_W    = $clog2(LANES)
) (
  input  logic              valid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [LANE_W-1:0] addr_lo,
  output access_t           acc,
  output logic [LANE_W-1:0] lane,
  output logic              word_misaligned
);
  always_comb begin
    acc = '0;
    if (valid) begin
      unique case (opcode)
        OPC_LD_BYTE: acc = '{active: 1'b1, is_store: 1'b0, is_word: 1'b0};
        OPC_LD_WORD: acc = '{active: 1'b1, is_store: 1'b0, is_word: 1'b1};
        OPC_ST_BYTE: acc = '{active: 1'b1, is_store: 1'b1, is_word: 1'b0};
        OPC_ST_WORD: acc = '{active: 1'b1, is_store: 1'b1, is_word: 1'b1};
        default:     acc = '0;
      endcase
    end
  end

  generate
    if (BIG_ENDIAN) begin : g_big
      assign lane = LANE_W'(LANES - 1) - addr_lo;
    end else begin : g_little
      assign lane = addr_lo;
    end
  endgenerate

  assign word_misaligned = acc.active && acc.is_word && (addr_lo != '0);
endmodule

// File: rtl/lsu_store_align.sv
module lsu_store_align
  import lsu_pkg::*;
#(
  parameter int DATA_W  = 32,
  localparam int BYTE_W = 8,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int LANE_W = $clog2(LANES)
) (
  input  access_t           acc,
  input  logic [LANE_W-1:0] lane,
  input  logic              word_misaligned,
  input  logic [DATA_W-1:0] store_data,
  output logic [LANES-1:0]  mask,
  output logic [DATA_W-1:0] data
);
  logic byte_st;
  logic word_st;

  assign byte_st = acc.active && acc.is_store && !acc.is_word;
  assign word_st = acc.active && acc.is_store && acc.is_word && !word_misaligned;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hit;
    assign hit = (byte_st && (lane == LANE_W'(g))) || word_st;
    assign mask[g] = hit;
    always_comb begin
      if (byte_st)      data[g*BYTE_W +: BYTE_W] = store_data[BYTE_W-1:0];
      else if (word_st) data[g*BYTE_W +: BYTE_W] = store_data[g*BYTE_W +: BYTE_W];
      else              data[g*BYTE_W +: BYTE_W] = '0;
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
  parameter int DATA_W  = 32,
  localparam int BYTE_W = 8,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              is_word,
  input  logic [LANE_W-1:0] lane,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] result
);
  logic [BYTE_W-1:0] lane_bytes [LANES];
  logic [BYTE_W-1:0] picked;

  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign lane_bytes[g] = rdata[g*BYTE_W +: BYTE_W];
  end

  assign picked = lane_bytes[lane];
  assign result = is_word ? rdata : {{(DATA_W-BYTE_W){picked[BYTE_W-1]}}, picked};
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter bit BIG_ENDIAN = 1'b1,
  localparam int LANES     = DATA_W / 8,
  localparam int LANE_W    = $clog2(LANES)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic [OPC_W-1:0]         req_opcode,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_store_data,
  input  logic [DATA_W-1:0]        mem_rdata,
  output logic [ADDR_W-LANE_W-1:0] wr_word_addr,
  output logic [LANES-1:0]         wr_mask,
  output logic [DATA_W-1:0]        wr_data,
  output logic                     load_valid,
  output logic [DATA_W-1:0]        load_result,
  output logic                     misaligned
);
  access_t           acc;
  logic [LANE_W-1:0] lane;
  logic              mis_c;
  logic [LANES-1:0]  mask_c;
  logic [DATA_W-1:0] data_c;
  logic [DATA_W-1:0] result_c;
  logic              is_load;

  lsu_access_decode #(.LANES(LANES), .BIG_ENDIAN(BIG_ENDIAN)) decode_i (
    .valid           (req_valid),
    .opcode          (req_opcode),
    .addr_lo         (req_addr[LANE_W-1:0]),
    .acc             (acc),
    .lane            (lane),
    .word_misaligned (mis_c)
  );

  lsu_store_align #(.DATA_W(DATA_W)) store_i (
    .acc             (acc),
    .lane            (lane),
    .word_misaligned (mis_c),
    .store_data      (req_store_data),
    .mask            (mask_c),
    .data            (data_c)
  );

  lsu_load_extract #(.DATA_W(DATA_W)) load_i (
    .is_word (acc.is_word),
    .lane    (lane),
    .rdata   (mem_rdata),
    .result  (result_c)
  );

  assign is_load = acc.active && !acc.is_store;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_word_addr <= '0;
      wr_mask      <= '0;
      wr_data      <= '0;
      load_valid   <= 1'b0;
      load_result  <= '0;
      misaligned   <= 1'b0;
    end else begin
      if (req_valid) wr_word_addr <= req_addr[ADDR_W-1:LANE_W];
      wr_mask    <= mask_c;
      wr_data    <= data_c;
      load_valid <= is_load;
      misaligned <= mis_c;
      if (is_load) load_result <= result_c;
    end
  end
endmodule

// File: rtl/lsu_lane_unit_chk.sv
module lsu_lane_unit_chk #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     req_valid,
  input logic [5:0]               req_opcode,
  input logic [ADDR_W-1:0]        req_addr,
  input logic [DATA_W-1:0]        req_store_data,
  input logic [ADDR_W-LANE_W-1:0] wr_word_addr,
  input logic [LANES-1:0]         wr_mask,
  input logic [DATA_W-1:0]        wr_data,
  input logic                     load_valid,
  input logic [DATA_W-1:0]        load_result,
  input logic                     misaligned
);
  a_r9_load_no_write: assert property (@(posedge clk) disable iff (rst)
    load_valid |-> wr_mask == '0);

  a_r9_idle_data_zero: assert property (@(posedge clk) disable iff (rst)
    (wr_mask == '0) |-> wr_data == '0);

  a_r6_mask_shape: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_mask) || ($countones(wr_mask) == LANES));

  a_r6_byte_replicated: assert property (@(posedge clk) disable iff (rst)
    ($countones(wr_mask) == 1) |-> wr_data == {LANES{wr_data[7:0]}});

  a_r8_misaligned_no_write: assert property (@(posedge clk) disable iff (rst)
    misaligned |-> wr_mask == '0);

  a_r7_word_store: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_opcode == 6'h2B && req_addr[LANE_W-1:0] == '0)
      |=> (wr_mask == '1 && wr_data == $past(req_store_data)));

  a_r4_sign_fill: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_opcode == 6'h20)
      |=> (load_valid && load_result[DATA_W-1:8] == {(DATA_W-8){load_result[7]}}));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (wr_mask == '0 && !load_valid && !misaligned && $stable(load_result)));

  a_r10_word_addr: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> wr_word_addr == $past(req_addr[ADDR_W-1:LANE_W]));
endmodule

bind lsu_lane_unit lsu_lane_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .req_opcode     (req_opcode),
  .req_addr       (req_addr),
  .req_store_data (req_store_data),
  .wr_word_addr   (wr_word_addr),
  .wr_mask        (wr_mask),
  .wr_data        (wr_data),
  .load_valid     (load_valid),
  .load_result    (load_result),
  .misaligned     (misaligned)
);

// File: tb/lsu_lane_unit_tb_top.sv
`timescale 1ns/1ps
module lsu_lane_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic preload = 1'b1;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [5:0]  req_opcode = '0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_store_data = '0;

  // index 0: big-endian instance, index 1: little-endian instance
  logic [31:0] rdata_o [2];
  logic [29:0] waddr_o [2];
  logic [3:0]  mask_o  [2];
  logic [31:0] wdata_o [2];
  logic        lv_o    [2];
  logic [31:0] res_o   [2];
  logic        mis_o   [2];

  logic [31:0] mem   [2][16];
  logic [7:0]  ref_b [2][64];
  logic [31:0] exp_res [2];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  lsu_lane_unit #(.BIG_ENDIAN(1'b1)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_opcode(req_opcode),
    .req_addr(req_addr), .req_store_data(req_store_data), .mem_rdata(rdata_o[0]),
    .wr_word_addr(waddr_o[0]), .wr_mask(mask_o[0]), .wr_data(wdata_o[0]),
    .load_valid(lv_o[0]), .load_result(res_o[0]), .misaligned(mis_o[0]));

  lsu_lane_unit #(.BIG_ENDIAN(1'b0)) dut_le_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_opcode(req_opcode),
    .req_addr(req_addr), .req_store_data(req_store_data), .mem_rdata(rdata_o[1]),
    .wr_word_addr(waddr_o[1]), .wr_mask(mask_o[1]), .wr_data(wdata_o[1]),
    .load_valid(lv_o[1]), .load_result(res_o[1]), .misaligned(mis_o[1]));

  function automatic logic [31:0] init_word(int w);
    return 32'h8041C37F ^ (32'(w) * 32'h01010101);
  endfunction

  // behavioural word memories, written by the DUT outputs
  for (genvar e = 0; e < 2; e++) begin : g_mem
    assign rdata_o[e] = mem[e][req_addr[5:2]];
    always_ff @(posedge clk) begin
      if (preload) begin
        for (int w = 0; w < 16; w++) mem[e][w] <= init_word(w);
      end else begin
        for (int k = 0; k < 4; k++)
          if (mask_o[e][k]) mem[e][waddr_o[e][3:0]][8*k +: 8] <= wdata_o[e][8*k +: 8];
      end
    end
  end

  function automatic int lane_of(int e, int off);
    return (e == 0) ? 3 - off : off;
  endfunction

  function automatic logic [31:0] ref_word(int e, logic [31:0] a);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) w[lane_of(e, i)*8 +: 8] = ref_b[e][a[5:2]*4 + i];
    return w;
  endfunction

  task automatic chk(string tag, string what, int e, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s inst%0d actual=%h expected=%h", tag, what, e, act, exp);
    end
  endtask

  // one clock with the given inputs; compares both instances one edge later
  task automatic cyc(logic v, logic [5:0] op, logic [31:0] a, logic [31:0] d, string tag);
    logic [3:0]  em [2];
    logic [31:0] ed [2];
    logic is_ld, is_st, is_w, mis;
    is_ld = v && (op == 6'h20 || op == 6'h23);
    is_st = v && (op == 6'h28 || op == 6'h2B);
    is_w  = (op == 6'h23 || op == 6'h2B);
    mis   = (is_ld || is_st) && is_w && (a[1:0] != 2'b00);
    for (int e = 0; e < 2; e++) begin
      em[e] = '0;
      ed[e] = '0;
      if (is_ld) begin
        if (is_w) exp_res[e] = ref_word(e, a);
        else      exp_res[e] = {{24{ref_b[e][a[5:0]][7]}}, ref_b[e][a[5:0]]};
      end
      if (is_st && !is_w) begin
        em[e] = 4'(1 << lane_of(e, int'(a[1:0])));
        ed[e] = {4{d[7:0]}};
        ref_b[e][a[5:0]] = d[7:0];
      end
      if (is_st && is_w && !mis) begin
        em[e] = 4'hF;
        ed[e] = d;
        for (int i = 0; i < 4; i++) ref_b[e][a[5:2]*4 + i] = d[lane_of(e, i)*8 +: 8];
      end
    end
    req_valid = v; req_opcode = op; req_addr = a; req_store_data = d;
    @(posedge clk);
    #1;
    for (int e = 0; e < 2; e++) begin
      chk(tag, "wr_mask", e, 32'(mask_o[e]), 32'(em[e]));
      chk(tag, "wr_data", e, wdata_o[e], ed[e]);
      chk(tag, "load_valid", e, 32'(lv_o[e]), 32'(is_ld));
      chk(tag, "misaligned", e, 32'(mis_o[e]), 32'(mis));
      chk(tag, "load_result", e, res_o[e], exp_res[e]);
      if (v) chk("R10", "wr_word_addr", e, 32'(waddr_o[e]), 32'(a[31:2]));
    end
    @(negedge clk);
  endtask

  // request followed by an idle cycle so the memory write lands first
  task automatic req(logic [5:0] op, logic [31:0] a, logic [31:0] d, string tag);
    cyc(1'b1, op, a, d, tag);
    cyc(1'b0, 6'h00, 32'h0, 32'h0, "R1");
  endtask

  task automatic check_reset_state();
    for (int e = 0; e < 2; e++) begin
      chk("R2", "reset wr_mask", e, 32'(mask_o[e]), 32'h0);
      chk("R2", "reset wr_data", e, wdata_o[e], 32'h0);
      chk("R2", "reset wr_word_addr", e, 32'(waddr_o[e]), 32'h0);
      chk("R2", "reset load_valid", e, 32'(lv_o[e]), 32'h0);
      chk("R2", "reset misaligned", e, 32'(mis_o[e]), 32'h0);
      chk("R2", "reset load_result", e, res_o[e], 32'h0);
      exp_res[e] = '0;
    end
  endtask

  initial begin
    for (int w = 0; w < 16; w++)
      for (int i = 0; i < 4; i++) begin
        ref_b[0][w*4 + i] = init_word(w)[(3-i)*8 +: 8];
        ref_b[1][w*4 + i] = init_word(w)[i*8 +: 8];
      end
    repeat (3) @(posedge clk);
    #1;
    check_reset_state();
    @(negedge clk);
    rst = 1'b0;
    preload = 1'b0;

    // R11: endianness example, word 5 at address 8, then bytes 8 and 11
    req(6'h2B, 32'd8, 32'h00000005, "R7");
    req(6'h20, 32'd8, 32'h0, "R11");
    req(6'h20, 32'd11, 32'h0, "R11");
    req(6'h23, 32'd8, 32'h0, "R5");

    // R3/R4: every lane of a preloaded word, negative and positive bytes
    for (int i = 0; i < 4; i++) req(6'h20, 32'd20 + 32'(i), 32'h0, "R4");
    req(6'h23, 32'd20, 32'h0, "R5");

    // R6: byte stores to each lane, read back by word and byte
    for (int i = 0; i < 4; i++) req(6'h28, 32'd36 + 32'(i), 32'hFFFF_FF00 | 32'(8'h91 + 8'(i)), "R6");
    req(6'h23, 32'd36, 32'h0, "R3");
    req(6'h20, 32'd38, 32'h0, "R4");

    // R7 and R8: aligned word store, misaligned store leaves memory alone
    req(6'h2B, 32'd48, 32'hDEAD_BEEF, "R7");
    req(6'h2B, 32'd49, 32'h1234_5678, "R8");
    req(6'h2B, 32'd51, 32'hCAFE_F00D, "R8");
    req(6'h23, 32'd48, 32'h0, "R8");
    req(6'h23, 32'd6, 32'h0, "R8");

    // R1: invalid request and unknown opcodes write nothing
    cyc(1'b0, 6'h2B, 32'd48, 32'h0BAD_0BAD, "R1");
    cyc(1'b0, 6'h00, 32'h0, 32'h0, "R1");
    req(6'h2C, 32'd48, 32'h0BAD_0BAD, "R1");
    req(6'h21, 32'd48, 32'h0BAD_0BAD, "R1");
    req(6'h23, 32'd48, 32'h0, "R1");

    // R9: a load of a lane right after a byte store
    req(6'h28, 32'd61, 32'h0000_007E, "R6");
    req(6'h20, 32'd61, 32'h0, "R9");

    // R2: reset in mid-run
    req(6'h23, 32'd20, 32'h0, "R5");
    rst = 1'b1;
    @(posedge clk);
    #1;
    check_reset_state();
    @(negedge clk);
    rst = 1'b0;
    req(6'h20, 32'd23, 32'h0, "R4");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule